// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block measures the pulse widths of two independent external signals against one shared 16-bit up-counter. The counter advances once per count tick, a single-cycle enable supplied by an external prescaler, and wraps freely through its full range. Each of the two asynchronous capture pins is brought into the clock domain by a flop synchronizer. It is then examined only on count ticks by a filter that accepts a new level after two consecutive equal samples. An edge selector then decides whether the confirmed transition should trigger a capture.

On a qualified transition the counter value of that tick is stored in a capture register, and a one-cycle interrupt request is raised. The routing is crossed: pin 0 feeds capture register 1 and request 1, and pin 1 feeds capture register 0 and request 0. Software computes a pulse width as the difference of two captures, and uses the sticky overflow flag to account for a counter wrap between them.

Top module: `dual_capture_timer`

## Requirements
- R1: While `run_en` is high, the counter increments by one on each cycle with `tick_en` high and wraps from 0xFFFF to 0. While `run_en` is low it is held at 0, so the first tick after enabling counts from 0.
- R2: A qualified transition on `cap_pin0` loads the counter value present at the confirming tick (before that tick's increment) into `capture1` and raises `irq1`. `capture0` and `irq0` are not affected.
- R3: A qualified transition on `cap_pin1` loads the counter value at the confirming tick into `capture0` and raises `irq0`. `capture1` and `irq1` are not affected.
- R4: Edge-select encoding per pin is 2'b00 for falling only, 2'b01 for rising only, 2'b10 for channel off (never captures) and 2'b11 for both edges. A confirmed transition of the non-selected direction causes no capture.
- R5: Pins are sampled only on count ticks, after a two-flop synchronizer. A capture needs the new level at two consecutive ticks, so a level held for fewer than two samples never captures, and pin changes between ticks have no effect until a tick arrives.
- R6: Each interrupt request is high for exactly one clock, in the first cycle in which its capture register shows the new value. A capture register never changes in a cycle where its request is low.
- R7: `ovf_flag` sets when the counter wraps from 0xFFFF to 0. It stays set until a cycle with `ovf_clr` high clears it. A wrap in the same cycle as a clear leaves it set.
- R8: While `run_en` is low, no capture or request occurs, and each filter follows its synchronized pin level. A pin level change made while stopped therefore triggers no capture after re-enabling.
- R9: When both pins confirm qualifying transitions on the same tick, both capture registers load the same counter value and both requests fire in the same cycle.
- R10: After a synchronous active-low reset, both capture registers are 0, both requests are low and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-clock enable from the prescaler, one cycle per tick |
| run_en | input | 1 | Enables counting and capturing |
| cap_pin0 | input | 1 | Asynchronous capture input 0 |
| cap_pin1 | input | 1 | Asynchronous capture input 1 |
| edge_sel0 | input | 2 | Edge select for `cap_pin0` |
| edge_sel1 | input | 2 | Edge select for `cap_pin1` |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| capture0 | output | 16 | Capture register loaded by `cap_pin1` |
| capture1 | output | 16 | Capture register loaded by `cap_pin0` |
| irq0 | output | 1 | Capture request for register 0 |
| irq1 | output | 1 | Capture request for register 1 |
| ovf_flag | output | 1 | Sticky counter wrap flag |

## Verification
A wrong counter state appears in the very next capture value, because every capture exposes the count directly. The bench therefore predicts each captured value from its own tally of ticks issued since enabling, including values taken after a full 65536-tick wrap. A filter stuck at the wrong level shows as a missing or spurious request, at the latest two ticks after the pin settles. A crossed or uncrossed routing error shows at once in which register and request respond to a given pin. Faults in the overflow flag show within one cycle of the wrap or of the clear strobe.

// File: rtl/ict_pkg.sv
// Package: shared types and helpers for the dual-channel input capture timer.
// Assumes a single clock domain; the edge-select code values are fixed by the
// programming model and must not be reordered.
package ict_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_OFF  = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Decide whether a confirmed transition to new_level is wanted by sel.
    function automatic logic edge_allowed(input edge_sel_e sel, input logic new_level);
        logic ok;
        case (sel)
            EDGE_FALL: ok = ~new_level;
            EDGE_RISE: ok = new_level;
            EDGE_BOTH: ok = 1'b1;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/ict_sync.sv
// Module: ict_sync
// Brings one asynchronous bit into the clk domain through a flop chain.
// Assumes STAGES >= 2; output lags the pin by STAGES clocks.
module ict_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/ict_edge_filter.sv
// Module: ict_edge_filter
// Samples a synchronized pin on count ticks, accepts a new level only after
// two consecutive equal samples, and flags the accepted transition when the
// edge select wants it. Assumes tick_en is a one-cycle enable.
module ict_edge_filter
    import ict_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       tick_en,
    input  logic       pin_sync,
    input  logic [1:0] edge_sel,
    output logic       edge_hit
);

    logic      prev_sample;   // pin level seen at the previous tick
    logic      stable_level;  // last level accepted by the filter
    logic      confirmed;     // new level seen at two ticks in a row
    edge_sel_e sel_e;

    assign sel_e     = edge_sel_e'(edge_sel);
    assign confirmed = (pin_sync == prev_sample) && (pin_sync != stable_level);
    assign edge_hit  = run_en && tick_en && confirmed && edge_allowed(sel_e, pin_sync);

    // Track the sample history; while stopped follow the pin directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sample  <= 1'b0;
            stable_level <= 1'b0;
        end else if (!run_en) begin
            prev_sample  <= pin_sync;
            stable_level <= pin_sync;
        end else if (tick_en) begin
            prev_sample <= pin_sync;
            if (confirmed) begin
                stable_level <= pin_sync;
            end
        end
    end

    // R5: the accepted level only moves on a tick while running.
    assert_level_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick_en) |=> $stable(stable_level));

endmodule

// File: rtl/ict_free_counter.sv
// Module: ict_free_counter
// Free-running up-counter advanced by the count tick, with a sticky wrap flag
// cleared by a write-one strobe. Assumes the counter restarts from zero on
// every run enable.
module ict_free_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick_en,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag
);

    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    logic advance;
    logic wrap;

    assign advance = run_en && tick_en;
    assign wrap    = advance && (count == CNT_MAX);

    // Count ticks while running, hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run_en) begin
            count <= '0;
        end else if (advance) begin
            count <= count + 1'b1;
        end
    end

    // Sticky wrap flag; a wrap outranks a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (wrap) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick_en && count != CNT_MAX) |=> count == $past(count) + 1'b1);

    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> count == '0);

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick_en && count == CNT_MAX) |=> ovf_flag);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

// File: rtl/ict_capture_chan.sv
// Module: ict_capture_chan
// Holds one capture register and its request pulse. Assumes load is a
// single-cycle strobe; the request rises in the cycle the register updates.
module ict_capture_chan #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] count_in,
    output logic [WIDTH-1:0] cap_value,
    output logic             irq
);

    // Latch the count on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
        end else if (load) begin
            cap_value <= count_in;
        end
    end

    // Raise the request for one cycle alongside the register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= load;
        end
    end

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_cap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(cap_value));

endmodule

// File: rtl/dual_capture_timer.sv
// Module: dual_capture_timer
// Two-channel input capture timer on one shared free-running counter. Pin 0
// feeds capture register 1 and pin 1 feeds capture register 0. Assumes
// tick_en comes from a prescaler in the same clock domain.
module dual_capture_timer #(
    parameter int CNT_WIDTH   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 run_en,
    input  logic                 cap_pin0,
    input  logic                 cap_pin1,
    input  logic [1:0]           edge_sel0,
    input  logic [1:0]           edge_sel1,
    input  logic                 ovf_clr,
    output logic [CNT_WIDTH-1:0] capture0,
    output logic [CNT_WIDTH-1:0] capture1,
    output logic                 irq0,
    output logic                 irq1,
    output logic                 ovf_flag
);

    localparam int NUM_CH = 2;

    logic [CNT_WIDTH-1:0] count;
    logic [NUM_CH-1:0]    pin_raw;
    logic [NUM_CH-1:0]    pin_sync;
    logic [NUM_CH-1:0]    edge_hit;
    logic [1:0]           sel_arr [NUM_CH];
    logic [CNT_WIDTH-1:0] cap_arr [NUM_CH];
    logic [NUM_CH-1:0]    irq_arr;

    assign pin_raw    = {cap_pin1, cap_pin0};
    assign sel_arr[0] = edge_sel0;
    assign sel_arr[1] = edge_sel1;

    ict_free_counter #(.WIDTH(CNT_WIDTH)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tick_en  (tick_en),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

    // Per-pin front end: synchronizer then tick-rate filter and edge select.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pin
        ict_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pin_raw[ch]),
            .dout  (pin_sync[ch])
        );

        ict_edge_filter u_filter (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_en   (run_en),
            .tick_en  (tick_en),
            .pin_sync (pin_sync[ch]),
            .edge_sel (sel_arr[ch]),
            .edge_hit (edge_hit[ch])
        );
    end

    // Per-register back end: register k is loaded by the opposite pin.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_cap
        ict_capture_chan #(.WIDTH(CNT_WIDTH)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (edge_hit[NUM_CH-1-k]),
            .count_in  (count),
            .cap_value (cap_arr[k]),
            .irq       (irq_arr[k])
        );
    end

    assign capture0 = cap_arr[0];
    assign capture1 = cap_arr[1];
    assign irq0     = irq_arr[0];
    assign irq1     = irq_arr[1];

    assert_irq0_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 |-> $past(tick_en && run_en));

    assert_irq1_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 |-> $past(tick_en && run_en));

    assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !irq0 && !irq1);

endmodule

// File: tb/tb_dual_capture_timer.sv
`timescale 1ns/1ps
module tb_dual_capture_timer;

    logic        clk = 1'b0;
    logic        rst_n, tick_en, run_en, cap_pin0, cap_pin1, ovf_clr;
    logic [1:0]  edge_sel0, edge_sel1;
    logic [15:0] capture0, capture1;
    logic        irq0, irq1, ovf_flag;

    int total = 0;
    int bad   = 0;
    int tcount = 0;
    int n_irq0 = 0, n_irq1 = 0;
    int last_irq0, last_irq1;
    int t0, e0, c0, c1, i0, i1;

    always #2.5 clk = ~clk;

    dual_capture_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .cap_pin0(cap_pin0), .cap_pin1(cap_pin1),
        .edge_sel0(edge_sel0), .edge_sel1(edge_sel1), .ovf_clr(ovf_clr),
        .capture0(capture0), .capture1(capture1),
        .irq0(irq0), .irq1(irq1), .ovf_flag(ovf_flag)
    );

    // Count request pulses as seen on the ports.
    always @(posedge clk) begin
        if (rst_n && irq0) n_irq0++;
        if (rst_n && irq1) n_irq1++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One spaced tick; irq levels just after its edge are kept.
    task automatic slow_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
            last_irq0 = irq0;
            last_irq1 = irq1;
            repeat (2) @(negedge clk);
            if (run_en) tcount++;
        end
    endtask

    task automatic fast_tick(input int n);
        @(negedge clk) tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        tcount += n;
    endtask

    // Change pins and let the synchronizer settle before the next tick.
    task automatic drive_pins(input logic p0, input logic p1);
        @(negedge clk);
        cap_pin0 = p0;
        cap_pin1 = p1;
        repeat (3) @(negedge clk);
    endtask

    task automatic snap();
        c0 = capture0; c1 = capture1; i0 = n_irq0; i1 = n_irq1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; run_en = 1'b0; ovf_clr = 1'b0;
        cap_pin0 = 1'b0; cap_pin1 = 1'b0; edge_sel0 = 2'b01; edge_sel1 = 2'b01;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 capture0", capture0, 0);
        chk("R10 capture1", capture1, 0);
        chk("R10 irqs", {irq0, irq1}, 0);
        chk("R10 ovf", ovf_flag, 0);

        run_en = 1'b1; tcount = 0;
        // R5: no sampling without ticks, one sample not enough
        drive_pins(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk("R5 no tick no capture", n_irq1, 0);
        slow_tick(1);
        chk("R5 single sample", n_irq1, 0);
        t0 = tcount;
        slow_tick(1);
        chk("R6 irq1 with update", last_irq1, 1);
        chk("R2 capture1 value", capture1, t0);
        chk("R1 count from zero", capture1, 1);
        chk("R2 irq1 count", n_irq1, 1);
        chk("R2 capture0 untouched", capture0, 0);
        chk("R2 irq0 untouched", n_irq0, 0);

        // R4: rising-only ignores falling
        snap();
        drive_pins(1'b0, 1'b0);
        slow_tick(3);
        chk("R4 rise-only ignores fall irq", n_irq1, i1);
        chk("R4 rise-only ignores fall cap", capture1, c1);

        // R3 with falling select on pin 1
        edge_sel1 = 2'b00;
        drive_pins(1'b0, 1'b1);
        slow_tick(3);
        chk("R4 fall-only ignores rise", n_irq0, 0);
        snap();
        drive_pins(1'b0, 1'b0);
        t0 = tcount;
        slow_tick(2);
        chk("R3 capture0 value", capture0, (t0 + 1) & 16'hFFFF);
        chk("R3 irq0 count", n_irq0, i0 + 1);
        chk("R3 capture1 untouched", capture1, c1);
        chk("R3 irq1 untouched", n_irq1, i1);
        chk("R6 irq0 with update", last_irq0, 1);

        // R4: both edges
        edge_sel0 = 2'b11;
        snap();
        drive_pins(1'b1, 1'b0);
        t0 = tcount;
        slow_tick(2);
        chk("R4 both rise", capture1, (t0 + 1) & 16'hFFFF);
        drive_pins(1'b0, 1'b0);
        t0 = tcount;
        slow_tick(2);
        chk("R4 both fall", capture1, (t0 + 1) & 16'hFFFF);
        chk("R4 both irq count", n_irq1, i1 + 2);

        // R4: channel off
        edge_sel0 = 2'b10;
        snap();
        drive_pins(1'b1, 1'b0);
        slow_tick(3);
        drive_pins(1'b0, 1'b0);
        slow_tick(3);
        chk("R4 off irq", n_irq1, i1);
        chk("R4 off cap", capture1, c1);

        // R5: one-sample pulse rejected
        edge_sel0 = 2'b11;
        snap();
        drive_pins(1'b1, 1'b0);
        slow_tick(1);
        drive_pins(1'b0, 1'b0);
        slow_tick(3);
        chk("R5 short pulse rejected", n_irq1, i1);

        // R9: simultaneous edges
        edge_sel0 = 2'b01; edge_sel1 = 2'b01;
        snap();
        drive_pins(1'b1, 1'b1);
        t0 = tcount;
        slow_tick(2);
        chk("R9 capture0", capture0, (t0 + 1) & 16'hFFFF);
        chk("R9 capture1", capture1, (t0 + 1) & 16'hFFFF);
        chk("R9 irqs same cycle", {last_irq0[0], last_irq1[0]}, 3);
        chk("R9 irq counts", (n_irq0 - i0) + (n_irq1 - i1), 2);

        // R8: stopped, pins change, nothing happens, even after re-enable
        @(negedge clk) run_en = 1'b0;
        snap();
        drive_pins(1'b0, 1'b0);
        slow_tick(3);
        chk("R8 stopped irqs", (n_irq0 - i0) + (n_irq1 - i1), 0);
        edge_sel0 = 2'b00; edge_sel1 = 2'b00;
        @(negedge clk) run_en = 1'b1;
        tcount = 0;
        slow_tick(3);
        chk("R8 no edge after re-enable", (n_irq0 - i0) + (n_irq1 - i1), 0);
        chk("R8 caps kept", capture0 + capture1, c0 + c1);

        // R1/R7: wrap
        edge_sel0 = 2'b01;
        fast_tick(65535 - tcount);
        @(negedge clk);
        chk("R7 no ovf before wrap", ovf_flag, 0);
        fast_tick(1);
        @(negedge clk);
        chk("R7 ovf on wrap", ovf_flag, 1);
        drive_pins(1'b1, 1'b0);
        t0 = tcount;
        slow_tick(2);
        chk("R1 wrapped capture", capture1, (t0 + 1) & 16'hFFFF);
        chk("R7 ovf sticky", ovf_flag, 1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        chk("R7 ovf cleared", ovf_flag, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule